// File: doc/BRIEF.md
# Registered DIMM Clock-Enable Power-Down Sequencer

This block sequences clock-enable power-down for a registered command/address buffer on a DDR3-style memory module. It registers the host clock-enable inputs onto the module-side clock-enable outputs. When every clock-enable input is sampled low, it shuts the buffer down in stages, each stage counted in clocks from the entry edge. First it forces the registered on-die-termination and clock-enable outputs low. Next it drops the address/command input enable, and one clock after that the parity input enable. After its own delay it releases the drive on the tri-stateable outputs. Outputs that are not gated here keep running, and so do input buffers that are not gated here.

When any clock-enable input goes high again, the input enables come back in the same clock. The chip-select outputs are held deselected for that one clock. Output drive returns after a programmable count. A parity mask covers the whole power-down window so that no false parity error is reported. The mask clears on the first command seen after normal operation resumes.

The chip-select path works in dual or quad mode. On the entry and exit clocks it flags chip-select combinations that would select control-word access instead of a normal command.

Top module: `rdimm_pd_seq`

## Requirements
- R1: Power-down is entered only on a clock edge where every bit of `dcke_i` is sampled low. With any bit high, the block stays active, and `qcke_o` equals `dcke_i` delayed by one clock.
- R2: `in_en_o` drops at the clock edge `T_INDIS` clocks after the entry edge. It stays low until exit.
- R3: `par_en_o` drops exactly one clock after `in_en_o` drops.
- R4: From the entry edge until exit, `qcke_o` and `qodt_o` are all zero. While the block is active, `qodt_o` equals `dodt_i` delayed by one clock.
- R5: `oe_o` drops at the edge `T_QDIS` clocks after the entry edge. That entry edge is also the edge where `qcke_o` went low.
- R6: Exit happens on the first edge in power-down where any bit of `dcke_i` is high. On that edge, `qcke_o` takes `dcke_i`, and `in_en_o` and `par_en_o` both return to 1.
- R7: On the exit edge and throughout power-down, `qcs_o` is all ones. At other times it equals `dcs_i` delayed by one clock. In dual mode (`quad_cs_i`=0), bits 3:2 of `qcs_o` are forced to 1.
- R8: In dual mode, `cs_err_o` is 1 for one clock after an entry or exit edge where `dcs_i[0]` and `dcs_i[1]` were both low. It is 0 otherwise.
- R9: In quad mode, `cs_err_o` is 1 for one clock after an entry or exit edge where bits 0 and 2, or bits 1 and 3, of `dcs_i` were both low. It is 0 otherwise.
- R10: `oe_o` returns to 1 at the edge `T_EN` clocks after the exit edge, and the block is active again from that edge. An entry request cannot be taken before then.
- R11: `par_mask_o` rises on the entry edge. It falls on the first edge after `oe_o` has returned where an enabled chip-select bit of `dcs_i` is low. A chip-select low between exit and that point does not clear it.
- R12: While `rst` is high at a clock edge, the following values are forced: `in_en_o`, `par_en_o` and `oe_o` are 1, `qcke_o` and `qodt_o` are 0, `qcs_o` is all ones, `par_mask_o` and `cs_err_o` are 0, and the state is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_cs_i | input | 1 | 1 selects quad chip-select mode |
| dcke_i | input | NUM_CKE | Clock-enable inputs from the host |
| dodt_i | input | NUM_CKE | Termination-control inputs from the host |
| dcs_i | input | NUM_CS | Active-low chip-select inputs |
| qcke_o | output | NUM_CKE | Registered clock-enable outputs |
| qodt_o | output | NUM_CKE | Registered termination-control outputs |
| qcs_o | output | NUM_CS | Registered, gated chip-select outputs |
| in_en_o | output | 1 | Address/command/termination/chip-select input buffer enable |
| par_en_o | output | 1 | Parity input buffer enable |
| oe_o | output | 1 | Drive enable for the tri-stateable outputs |
| par_mask_o | output | 1 | Masks the parity error output |
| cs_err_o | output | 1 | Illegal chip-select pattern on an entry or exit edge |

## Verification
Exit is tried at every delay from one clock after entry to well past the output-disable point. This separates the input-disable stage, the parity-disable stage and the output-disable stage, and shows whether an early exit leaves a stage half done. The exit edges use the clock-enable patterns 01, 10 and 11, which tells an any-bit-high exit from an all-bits-high exit. Partially low clock-enable patterns check that entry needs all bits low. A sweep of all sixteen chip-select values in both modes, on entry and on exit edges, separates the dual-mode pair check from the quad-mode pair checks. The same sweep shows that the flag appears only on those edges.

// File: rtl/rdimm_pd_pkg.sv
package rdimm_pd_pkg;
  typedef enum logic [1:0] {
    PD_ACTIVE = 2'd0,
    PD_DOWN   = 2'd1,
    PD_EXIT   = 2'd2
  } pd_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rdimm_pd_cnt.sv
module rdimm_pd_cnt #(
  parameter int W    = 4,
  parameter int MAXV = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  // start loads 1 so that the value after edge k+m is m+1
  always_comb begin
    if (start_i)
      cnt_nxt = W'(1);
    else if (run_i && (cnt_q < W'(MAXV)))
      cnt_nxt = cnt_q + W'(1);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rdimm_pd_csgate.sv
module rdimm_pd_csgate #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              quad_i,
  input  logic [NUM_CS-1:0] dcs_i,
  input  logic              force_hi_i,
  input  logic              check_i,
  output logic [NUM_CS-1:0] qcs_o,
  output logic              err_o,
  output logic              cmd_o
);
  localparam int HALF = NUM_CS / 2;

  logic [NUM_CS-1:0] eff_cs;
  logic [HALF-1:0]   pair_lo;
  logic              illegal;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_eff
    if (i < 2) begin : g_base
      assign eff_cs[i] = dcs_i[i];
    end else begin : g_ext
      assign eff_cs[i] = quad_i ? dcs_i[i] : 1'b1;
    end
  end

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    assign pair_lo[p] = ~dcs_i[p] & ~dcs_i[p+HALF];
  end

  assign illegal = quad_i ? (|pair_lo) : (~dcs_i[0] & ~dcs_i[1]);
  assign cmd_o   = ~(&eff_cs);

  always_ff @(posedge clk) begin
    if (rst) begin
      qcs_o <= '1;
      err_o <= 1'b0;
    end else begin
      qcs_o <= force_hi_i ? '1 : eff_cs;
      err_o <= check_i & illegal;
    end
  end
endmodule

// File: rtl/rdimm_pd_seq.sv
module rdimm_pd_seq
  import rdimm_pd_pkg::*;
#(
  parameter int NUM_CKE = 2,
  parameter int NUM_CS  = 4,
  parameter int T_INDIS = 3,
  parameter int T_QDIS  = 5,
  parameter int T_EN    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               quad_cs_i,
  input  logic [NUM_CKE-1:0] dcke_i,
  input  logic [NUM_CKE-1:0] dodt_i,
  input  logic [NUM_CS-1:0]  dcs_i,
  output logic [NUM_CKE-1:0] qcke_o,
  output logic [NUM_CKE-1:0] qodt_o,
  output logic [NUM_CS-1:0]  qcs_o,
  output logic               in_en_o,
  output logic               par_en_o,
  output logic               oe_o,
  output logic               par_mask_o,
  output logic               cs_err_o
);
  localparam int CNT_MAX = max_of3(T_INDIS + 1, T_QDIS, T_EN) + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             entry_evt, exit_evt, cmd_seen;
  int               n_int;

  assign entry_evt = (st_q == PD_ACTIVE) && (dcke_i == '0);
  assign exit_evt  = (st_q == PD_DOWN) && (|dcke_i);
  assign n_int     = int'(cnt_n);

  rdimm_pd_cnt #(.W(CNT_W), .MAXV(CNT_MAX)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start_i (entry_evt | exit_evt),
    .run_i   (st_q != PD_ACTIVE),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_n)
  );

  rdimm_pd_csgate #(.NUM_CS(NUM_CS)) u_cs (
    .clk        (clk),
    .rst        (rst),
    .quad_i     (quad_cs_i),
    .dcs_i      (dcs_i),
    .force_hi_i ((st_q == PD_DOWN)),
    .check_i    (entry_evt | exit_evt),
    .qcs_o      (qcs_o),
    .err_o      (cs_err_o),
    .cmd_o      (cmd_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PD_ACTIVE;
      qcke_o     <= '0;
      qodt_o     <= '0;
      in_en_o    <= 1'b1;
      par_en_o   <= 1'b1;
      oe_o       <= 1'b1;
      par_mask_o <= 1'b0;
    end else begin
      unique case (st_q)
        PD_ACTIVE: begin
          qcke_o <= dcke_i;
          if (entry_evt) begin
            st_q       <= PD_DOWN;
            qodt_o     <= '0;
            par_mask_o <= 1'b1;
          end else begin
            qodt_o <= dodt_i;
            if (par_mask_o && cmd_seen) par_mask_o <= 1'b0;
          end
        end
        PD_DOWN: begin
          if (exit_evt) begin
            st_q     <= PD_EXIT;
            qcke_o   <= dcke_i;
            qodt_o   <= dodt_i;
            in_en_o  <= 1'b1;
            par_en_o <= 1'b1;
          end else begin
            qcke_o   <= '0;
            qodt_o   <= '0;
            in_en_o  <= (n_int <= T_INDIS);
            par_en_o <= (n_int <= T_INDIS + 1);
            oe_o     <= oe_o & (n_int <= T_QDIS);
          end
        end
        PD_EXIT: begin
          qcke_o <= dcke_i;
          qodt_o <= dodt_i;
          if (n_int >= T_EN + 1) begin
            oe_o <= 1'b1;
            st_q <= PD_ACTIVE;
          end
        end
        default: st_q <= PD_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/rdimm_pd_chk.sv
module rdimm_pd_chk #(
  parameter int NUM_CKE = 2,
  parameter int NUM_CS  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CKE-1:0] qcke_o,
  input logic [NUM_CKE-1:0] qodt_o,
  input logic [NUM_CS-1:0]  qcs_o,
  input logic               in_en_o,
  input logic               par_en_o,
  input logic               oe_o,
  input logic               par_mask_o
);
  p_par_after_in_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(par_en_o) |-> (!in_en_o && $past(!in_en_o)));

  p_pd_levels_low_r4: assert property (@(posedge clk) disable iff (rst)
    !in_en_o |-> (qcke_o == '0 && qodt_o == '0));

  p_oe_off_after_cke_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_o) |-> (qcke_o == '0 && qodt_o == '0 && par_mask_o));

  p_exit_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(in_en_o) |-> (qcs_o == '1));

  p_mask_on_reenable_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> par_mask_o);
endmodule

bind rdimm_pd_seq rdimm_pd_chk #(.NUM_CKE(NUM_CKE), .NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .qcke_o     (qcke_o),
  .qodt_o     (qodt_o),
  .qcs_o      (qcs_o),
  .in_en_o    (in_en_o),
  .par_en_o   (par_en_o),
  .oe_o       (oe_o),
  .par_mask_o (par_mask_o)
);

// File: tb/sim_rdimm_pd_seq.sv
module sim_rdimm_pd_seq;
  localparam int TI = 3;
  localparam int TQ = 5;
  localparam int TE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       quad = 1'b0;
  logic [1:0] dcke = 2'b11;
  logic [1:0] dodt = 2'b00;
  logic [3:0] dcs = 4'b1111;
  logic [1:0] qcke, qodt;
  logic [3:0] qcs;
  logic       in_en, par_en, oe, mask, err;
  int         vectors = 0;
  int         miscompares = 0;

  always #2 clk = ~clk;

  rdimm_pd_seq #(.NUM_CKE(2), .NUM_CS(4), .T_INDIS(TI), .T_QDIS(TQ), .T_EN(TE)) u0 (
    .clk(clk), .rst(rst), .quad_cs_i(quad), .dcke_i(dcke), .dodt_i(dodt), .dcs_i(dcs),
    .qcke_o(qcke), .qodt_o(qodt), .qcs_o(qcs), .in_en_o(in_en), .par_en_o(par_en),
    .oe_o(oe), .par_mask_o(mask), .cs_err_o(err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic q, input logic [3:0] v);
    if (q) return (!v[0] && !v[2]) || (!v[1] && !v[3]);
    return !v[0] && !v[1];
  endfunction

  task automatic settle_active();
    dcke = 2'b11; dcs = 4'b1111;
    repeat (TE + 3) step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R12 reset state
    chk("R12 in_en", in_en, 1); chk("R12 par_en", par_en, 1); chk("R12 oe", oe, 1);
    chk("R12 qcke", qcke, 0); chk("R12 qodt", qodt, 0); chk("R12 qcs", qcs, 4'hf);
    chk("R12 mask", mask, 0); chk("R12 err", err, 0);

    // R1 partial clock-enable patterns do not enter; R4 odt follows when active
    for (int p = 1; p < 3; p++) begin
      dcke = 2'(p); dodt = 2'(3 - p);
      repeat (TI + 3) begin
        step();
        chk("R1 in_en stays", in_en, 1);
        chk("R1 qcke follows", qcke, p);
        chk("R4 qodt follows", qodt, 3 - p);
        chk("R1 mask stays", mask, 0);
      end
    end
    dodt = 2'b11;
    settle_active();

    // exit-delay sweep
    for (int d = 1; d <= TQ + 4; d++) begin
      logic [1:0] xp;
      xp = (d % 3 == 0) ? 2'b11 : ((d % 3 == 1) ? 2'b01 : 2'b10);
      quad = 1'b0;
      settle_active();
      dcke = 2'b00; dcs = 4'b1111;
      step();
      chk("R1 entry qcke", qcke, 0); chk("R4 entry qodt", qodt, 0);
      chk("R11 mask rise", mask, 1); chk("R2 in_en m0", in_en, 1);
      for (int m = 1; m < d; m++) begin
        step();
        chk("R2 in_en", in_en, (m < TI));
        chk("R3 par_en", par_en, (m < TI + 1));
        chk("R5 oe", oe, (m < TQ));
        chk("R4 qcke", qcke, 0); chk("R4 qodt", qodt, 0);
        chk("R7 qcs pd", qcs, 4'hf);
      end
      dcke = xp; dcs = 4'b0110;
      step();
      chk("R6 qcke", qcke, xp); chk("R6 in_en", in_en, 1); chk("R6 par_en", par_en, 1);
      chk("R7 qcs exit", qcs, 4'hf); chk("R10 oe at exit", oe, (d - 1 < TQ));
      chk("R8 no err", err, 0);
      step();
      chk("R7 qcs follows dual", qcs, 4'b1110);
      chk("R11 mask held in exit", mask, 1);
      chk("R10 oe k1", oe, (1 >= TE) ? 1 : (d - 1 < TQ));
      dcs = 4'b1111;
      for (int k = 2; k <= TE + 1; k++) begin
        step();
        chk("R10 oe", oe, (k >= TE) ? 1 : (d - 1 < TQ));
        chk("R11 mask", mask, 1);
      end
      dcs = 4'b1101;
      step();
      chk("R11 mask clear", mask, 0); chk("R7 qcs", qcs, 4'b1111 & 4'b1101);
      dcs = 4'b1111;
    end

    // chip-select legality sweep, both modes
    for (int q = 0; q < 2; q++) begin
      for (int v = 0; v < 16; v++) begin
        quad = q[0];
        settle_active();
        dcke = 2'b00; dcs = 4'(v);
        step();
        chk(q ? "R9 entry err" : "R8 entry err", err, exp_err(q[0], 4'(v)));
        step();
        chk(q ? "R9 pd no err" : "R8 pd no err", err, 0);
        dcke = 2'b11;
        step();
        chk(q ? "R9 exit err" : "R8 exit err", err, exp_err(q[0], 4'(v)));
        step();
        chk(q ? "R9 after err" : "R8 after err", err, 0);
        chk("R7 qcs mode", qcs, q ? 4'(v) : {2'b11, 2'(v)});
        dcs = 4'b1111;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule